// File: doc/BRIEF.md
# Shared-Reference Strobed Word Bridge

This block carries control words between two devices that run from the same fast reference clock. Each device makes its own slow clock by dividing the fast clock by four. Neither device knows how its slow clock lines up with the other one, so there are four possible phase offsets between them. The transmit half takes a word from its slow domain and drives it onto the link, where the word stays unchanged for a whole slow period. It also marks the word with an enable strobe that lasts one fast cycle. The receive half samples the strobe and the data with the fast clock, keeps the word, and releases it at the next boundary of its own slow clock together with a valid flag that lasts one slow cycle.

Both halves sit in one module, and each half has its own reset, because in a system they belong to different devices. The link outputs of the transmit half leave the block, and the link inputs of the receive half enter it separately. A system connects them through pads. A bench connects them directly.

Top module: `fastclk_word_bridge`

## Requirements
- R1: Each half has its own divider. After its reset is sampled low, the side's slot output (`tx_slot` or `rx_slot`) is high for exactly one fast cycle in every four. It is high after the 3rd, 7th, 11th, ... rising clock edges counted from the first edge at which that reset is low.
- R2: A launch takes place at a rising edge where `tx_slot` and `tx_send` are both high. After a launch, `link_strobe_o` is high for exactly the next fast cycle. At all other times it is low.
- R3: At a launch edge, `link_data_o` takes the value of `tx_word`. It then holds that value until the next launch. While `tx_send` is low at slot edges, nothing is launched, the strobe stays low and `link_data_o` does not change.
- R4: The receiver registers `link_strobe_i` and `link_data_i` once in the fast domain. A word launched at edge c appears on `rx_word` at the first rx slot edge that is at or after edge c+2.
- R5: `rx_valid` and `rx_word` change only at rx slot edges. `rx_valid` stays high for exactly one slow cycle (four fast cycles) for each delivered word. `rx_word` keeps the last delivered word.
- R6: Every strobe gives exactly one valid slow cycle. Words arrive in launch order, with none lost and none duplicated, for each of the four phase offsets between the dividers.
- R7: The synchronous active-high reset `tx_rst` clears the tx divider, the strobe and `link_data_o`. The reset `rx_rst` clears the rx divider, the capture stage, the held word, `rx_valid` and `rx_word` (all to zero).
- R8: The word width is the parameter `DATA_W` (default 8). All DATA_W bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared fast reference clock |
| tx_rst | input | 1 | Synchronous reset of the transmit half |
| tx_send | input | 1 | Request to launch `tx_word` at the next tx slot edge |
| tx_word | input | DATA_W | Word to be sent |
| tx_slot | output | 1 | Transmit-side slow-clock enable |
| link_strobe_o | output | 1 | Strobe driven onto the link, one fast cycle per word |
| link_data_o | output | DATA_W | Data driven onto the link, held for a slow period |
| rx_rst | input | 1 | Synchronous reset of the receive half |
| link_strobe_i | input | 1 | Strobe arriving from the link |
| link_data_i | input | DATA_W | Data arriving from the link |
| rx_slot | output | 1 | Receive-side slow-clock enable |
| rx_valid | output | 1 | Word valid for one receive slow cycle |
| rx_word | output | DATA_W | Delivered word |

## Verification
The bench releases the receive reset zero, one, two and three fast cycles after the transmit reset, so that every phase offset of the dividers is covered. Words are sent back to back at the full rate and also with gaps. The most likely slip is the offset in which the captured strobe arrives in the same cycle as the receive slot. A design that parks the word for a later slot in that case delivers it one slow cycle late. A design that both parks it and delivers it repeats the word. A design that drops the word or overwrites the held copy shows up as a missing or reordered entry against the queue that the bench keeps.

// File: rtl/fwb_pkg.sv
`timescale 1ns/1ps
package fwb_pkg;
   // Fast cycles per slow cycle on both sides of the link.
   localparam int unsigned FWB_RATIO_DEF = 4;
   // Default control word width.
   localparam int unsigned FWB_WIDTH_DEF = 8;
   // Fast-domain register stages from the link pins to the hand-over point.
   localparam int unsigned FWB_CAPTURE_LAT = 2;
endpackage

// File: rtl/fwb_slot_gen.sv
`timescale 1ns/1ps
module fwb_slot_gen #(
   parameter int unsigned RATIO = fwb_pkg::FWB_RATIO_DEF
) (
   input  logic clk,
   input  logic rst,
   output logic slot
);
   localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
   localparam bit POW2 = ((RATIO & (RATIO - 1)) == 0);

   logic [CW-1:0] phase_q;

   if (RATIO < 2) begin : g_bad_ratio
      $error("fwb_slot_gen: RATIO must be at least 2");
   end

   if (POW2) begin : g_wrap
      always_ff @(posedge clk) begin
         if (rst) phase_q <= '0;
         else     phase_q <= phase_q + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (rst)                  phase_q <= '0;
         else if (phase_q == LAST) phase_q <= '0;
         else                      phase_q <= phase_q + 1'b1;
      end
   end

   assign slot = (phase_q == LAST);
endmodule

// File: rtl/fwb_tx.sv
`timescale 1ns/1ps
module fwb_tx #(
   parameter int unsigned W     = fwb_pkg::FWB_WIDTH_DEF,
   parameter int unsigned RATIO = fwb_pkg::FWB_RATIO_DEF
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         send,
   input  logic [W-1:0] word,
   output logic         slot,
   output logic         stb,
   output logic [W-1:0] data
);
   logic launch;

   fwb_slot_gen #(.RATIO(RATIO)) u_div (
      .clk  (clk),
      .rst  (rst),
      .slot (slot)
   );

   assign launch = slot & send;

   always_ff @(posedge clk) begin
      if (rst) begin
         stb  <= 1'b0;
         data <= '0;
      end else begin
         stb <= launch;
         if (launch) data <= word;
      end
   end
endmodule

// File: rtl/fwb_rx.sv
`timescale 1ns/1ps
module fwb_rx #(
   parameter int unsigned W     = fwb_pkg::FWB_WIDTH_DEF,
   parameter int unsigned RATIO = fwb_pkg::FWB_RATIO_DEF
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         stb_in,
   input  logic [W-1:0] data_in,
   output logic         slot,
   output logic         valid,
   output logic [W-1:0] word
);
   logic         cap_stb;
   logic [W-1:0] cap_data;
   logic         pend;
   logic [W-1:0] hold;

   fwb_slot_gen #(.RATIO(RATIO)) u_div (
      .clk  (clk),
      .rst  (rst),
      .slot (slot)
   );

   // Fast-domain capture of the link.
   always_ff @(posedge clk) begin
      if (rst) begin
         cap_stb  <= 1'b0;
         cap_data <= '0;
      end else begin
         cap_stb  <= stb_in;
         cap_data <= data_in;
      end
   end

   // Hand-over: a word captured on a slot edge bypasses the hold register.
   always_ff @(posedge clk) begin
      if (rst) begin
         pend  <= 1'b0;
         hold  <= '0;
         valid <= 1'b0;
         word  <= '0;
      end else if (slot) begin
         valid <= cap_stb | pend;
         if (cap_stb)   word <= cap_data;
         else if (pend) word <= hold;
         pend <= 1'b0;
      end else if (cap_stb) begin
         hold <= cap_data;
         pend <= 1'b1;
      end
   end
endmodule

// File: rtl/fastclk_word_bridge.sv
`timescale 1ns/1ps
module fastclk_word_bridge #(
   parameter int unsigned DATA_W = fwb_pkg::FWB_WIDTH_DEF,
   parameter int unsigned RATIO  = fwb_pkg::FWB_RATIO_DEF
) (
   input  logic              clk,
   input  logic              tx_rst,
   input  logic              tx_send,
   input  logic [DATA_W-1:0] tx_word,
   output logic              tx_slot,
   output logic              link_strobe_o,
   output logic [DATA_W-1:0] link_data_o,
   input  logic              rx_rst,
   input  logic              link_strobe_i,
   input  logic [DATA_W-1:0] link_data_i,
   output logic              rx_slot,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_word
);
   if (DATA_W < 1) begin : g_bad_width
      $error("fastclk_word_bridge: DATA_W must be at least 1");
   end
   if (RATIO < fwb_pkg::FWB_CAPTURE_LAT) begin : g_bad_ratio
      $error("fastclk_word_bridge: RATIO too small for the capture latency");
   end

   fwb_tx #(.W(DATA_W), .RATIO(RATIO)) u_tx (
      .clk  (clk),
      .rst  (tx_rst),
      .send (tx_send),
      .word (tx_word),
      .slot (tx_slot),
      .stb  (link_strobe_o),
      .data (link_data_o)
   );

   fwb_rx #(.W(DATA_W), .RATIO(RATIO)) u_rx (
      .clk     (clk),
      .rst     (rx_rst),
      .stb_in  (link_strobe_i),
      .data_in (link_data_i),
      .slot    (rx_slot),
      .valid   (rx_valid),
      .word    (rx_word)
   );
endmodule

// File: rtl/fwb_bridge_chk.sv
`timescale 1ns/1ps
module fwb_bridge_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         tx_rst,
   input logic         rx_rst,
   input logic         tx_slot,
   input logic         rx_slot,
   input logic         link_strobe_o,
   input logic [W-1:0] link_data_o,
   input logic         rx_valid,
   input logic [W-1:0] rx_word
);
   p_tx_slot_single_r1: assert property (@(posedge clk) disable iff (tx_rst)
      tx_slot |=> !tx_slot);

   p_rx_slot_single_r1: assert property (@(posedge clk) disable iff (rx_rst)
      rx_slot |=> !rx_slot);

   p_strobe_one_cycle_r2: assert property (@(posedge clk) disable iff (tx_rst)
      link_strobe_o |=> !link_strobe_o);

   p_strobe_after_slot_r2: assert property (@(posedge clk) disable iff (tx_rst)
      link_strobe_o |-> $past(tx_slot));

   p_link_data_held_r3: assert property (@(posedge clk) disable iff (tx_rst)
      !$stable(link_data_o) |-> ($past(tx_slot) && link_strobe_o));

   p_valid_on_slot_r5: assert property (@(posedge clk) disable iff (rx_rst)
      !$stable(rx_valid) |-> $past(rx_slot));

   p_word_on_slot_r5: assert property (@(posedge clk) disable iff (rx_rst)
      !$stable(rx_word) |-> ($past(rx_slot) && rx_valid));
endmodule

bind fastclk_word_bridge fwb_bridge_chk #(.W(DATA_W)) u_chk (
   .clk           (clk),
   .tx_rst        (tx_rst),
   .rx_rst        (rx_rst),
   .tx_slot       (tx_slot),
   .rx_slot       (rx_slot),
   .link_strobe_o (link_strobe_o),
   .link_data_o   (link_data_o),
   .rx_valid      (rx_valid),
   .rx_word       (rx_word)
);

// File: tb/tb_fastclk_word_bridge.sv
`timescale 1ns/1ps
module tb_fastclk_word_bridge;
   localparam int W = 8;
   localparam int R = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         tx_rst, rx_rst, tx_send;
   logic [W-1:0] tx_word;
   logic         tx_slot, rx_slot, lnk_stb, rx_valid;
   logic [W-1:0] lnk_data, rx_word;

   fastclk_word_bridge #(.DATA_W(W), .RATIO(R)) dut (
      .clk           (clk),
      .tx_rst        (tx_rst),
      .tx_send       (tx_send),
      .tx_word       (tx_word),
      .tx_slot       (tx_slot),
      .link_strobe_o (lnk_stb),
      .link_data_o   (lnk_data),
      .rx_rst        (rx_rst),
      .link_strobe_i (lnk_stb),
      .link_data_i   (lnk_data),
      .rx_slot       (rx_slot),
      .rx_valid      (rx_valid),
      .rx_word       (rx_word)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int tx_n = 0;
   int rx_n = 0;
   bit started = 0;
   bit done = 0;

   bit           e_stb = 0;
   bit           e_valid = 0;
   logic [W-1:0] e_ldata = '0;
   logic [W-1:0] e_word = '0;

   typedef struct {
      logic [W-1:0] w;
      int           t;
   } sent_t;
   sent_t q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Behavioural reference: slot counters, a queue of launched words.
   always @(posedge clk) begin
      automatic bit launch = !tx_rst && (tx_n % R == R - 1) && tx_send;
      automatic bit rslot  = !rx_rst && (rx_n % R == R - 1);
      if (tx_rst) begin
         e_stb   = 0;
         e_ldata = '0;
      end else begin
         e_stb = launch;
         if (launch) begin
            e_ldata = tx_word;
            q.push_back('{w: tx_word, t: cyc});
         end
      end
      if (rx_rst) begin
         e_valid = 0;
         e_word  = '0;
      end else if (rslot) begin
         if (q.size() > 0 && q[0].t + 2 <= cyc) begin
            e_valid = 1;
            e_word  = q[0].w;
            void'(q.pop_front());
         end else begin
            e_valid = 0;
         end
      end
      tx_n = tx_rst ? 0 : tx_n + 1;
      rx_n = rx_rst ? 0 : rx_n + 1;
      cyc++;
      started = 1;
   end

   // Per-cycle comparison away from the active edge.
   always @(negedge clk) begin
      if (started && !done) begin
         chk("R1 tx_slot", 32'(tx_slot), 32'(tx_n % R == R - 1));
         chk("R1 rx_slot", 32'(rx_slot), 32'(rx_n % R == R - 1));
         chk("R2 link_strobe", 32'(lnk_stb), 32'(e_stb));
         chk("R3 link_data", 32'(lnk_data), 32'(e_ldata));
         chk("R5 rx_valid", 32'(rx_valid), 32'(e_valid));
         chk("R4/R8 rx_word", 32'(rx_word), 32'(e_word));
      end
   end

   initial begin
      tx_rst = 1'b1; rx_rst = 1'b1; tx_send = 1'b0; tx_word = '0;
      for (int p = 0; p < R; p++) begin
         tx_rst = 1'b1; rx_rst = 1'b1; tx_send = 1'b0;
         repeat (3) @(negedge clk);
         // R7: both halves cleared while held in reset
         chk("R7 reset strobe", 32'(lnk_stb), 32'd0);
         chk("R7 reset link_data", 32'(lnk_data), 32'd0);
         chk("R7 reset rx_valid", 32'(rx_valid), 32'd0);
         chk("R7 reset rx_word", 32'(rx_word), 32'd0);
         tx_rst = 1'b0;
         repeat (p) @(negedge clk);
         rx_rst = 1'b0;
         // full-rate burst, includes all-ones word for R8
         for (int i = 0; i < 8; i++) begin
            tx_send = 1'b1;
            tx_word = (i == 3) ? {W{1'b1}} : W'(8'h10 * p + i + 1);
            repeat (R) @(negedge clk);
         end
         // gapped traffic: idle slots must leave the link untouched (R3)
         for (int i = 0; i < 16; i++) begin
            tx_send = ($urandom % 3) != 0;
            tx_word = W'($urandom);
            repeat (R) @(negedge clk);
         end
         tx_send = 1'b0;
         tx_word = '1;
         repeat (4 * R) @(negedge clk);
         // R6: every launched word delivered once for this offset
         chk("R6 words outstanding", 32'(q.size()), 32'd0);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule